// File: doc/BRIEF.md
# Real-Time Interval Counter

The block keeps time from a 128 Hz tick. Four cascaded counters hold the elapsed fraction of a second (counted in 1/128 steps), seconds, minutes and hours. A run bit in the control register gates the whole cascade. The hour counter can wrap after 24 hours or after 255 hours. Software can load any of the four counters through a small register bus and read them back.

An interval timer sits beside the cascade. Its unit is one of the four cascade stages, and it counts that stage's advances up to the value in an 8-bit interval register. When the count is reached it sets a sticky flag in the control register, which is also driven onto an output pin for an interrupt controller. The timer then either reloads and keeps going, or stops until software re-arms it. Clearing the interval enable stops the timer and resets its count.

Top module: `rtic_top`

## Requirements
- R1: After reset, every readable register (addresses 0 to 5) reads 0 and `intvFlag` is low.
- R2: While the run bit (control bit 0) is 1, each `tick128` pulse advances the fraction counter (address 2) through 0..127. On the pulse that moves it from 127 back to 0, the seconds counter advances in the same cycle.
- R3: Seconds (address 3) and minutes (address 4) each count 0..59. Each wraps to 0 and advances the next stage on the same tick.
- R4: When the hour mode bit (control bit 6) is 1, hours (address 5) go from 23 to 0. When it is 0, hours go from 254 to 0.
- R5: While the run bit is 0, ticks change no time counter and do not advance the interval timer.
- R6: Bus map: 0 control, 1 interval, 2 fraction, 3 seconds, 4 minutes, 5 hours. A write to addresses 1 to 5 loads the value, and a read returns it. In the control register, bit 0 is run, bit 1 is interval enable, bit 2 is the flag, bit 3 is one-shot, bits 5:4 are the timebase and bit 6 is the hour mode. Bit 7 reads 0.
- R7: The timebase field selects the interval unit: 0 counts fraction advances, 1 counts seconds advances, 2 counts minutes advances and 3 counts hours advances.
- R8: With the interval enabled, the flag sets in the cycle of the N-th unit event after arming, where N is the interval register value. A value of 0 means 256 events.
- R9: With one-shot (bit 3) at 0, the timer restarts after each hit and sets the flag again after N more events.
- R10: With one-shot at 1, the timer stops after the first hit and sets no further flag until the interval enable is cleared and set again.
- R11: Writing interval enable 0 clears the interval count and holds it at 0. It does not clear the flag.
- R12: The flag stays set until a control write has bit 2 at 1. A control write with bit 2 at 0 leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick128 | input | 1 | One-cycle pulse at 128 Hz |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 3 | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data (combinational from busAddr) |
| intvFlag | output | 1 | Interval flag, same as control bit 2 |

## Verification
The assertions assume that software loads only in-range values into the time counters: fraction below 128, seconds and minutes below 60, and hours below 24 when the 24-hour mode is on. They also assume that a bus write and a counter's own range check never fight over the same register in a cycle they watch. Every load the bench makes respects these ranges. The bench issues bus writes only in cycles without a tick pulse, so no load coincides with counting. Timing is tracked by an arithmetic model of the cascade and by event counts worked out from the interval value.

// File: rtl/rtic_pkg.sv
`timescale 1ns/1ps
package rtic_pkg;
  localparam int DW     = 8;
  localparam int NSTAGE = 4;
  localparam int AW     = 3;
  localparam int TBW    = $clog2(NSTAGE);

  localparam logic [AW-1:0] A_CTRL = 3'd0;
  localparam logic [AW-1:0] A_INTV = 3'd1;
  localparam logic [AW-1:0] A_FRAC = 3'd2;

  localparam int B_RUN  = 0;
  localparam int B_IEN  = 1;
  localparam int B_FLAG = 2;
  localparam int B_ONCE = 3;
  localparam int B_TB   = 4;
  localparam int B_H24  = 6;

  localparam logic [DW-1:0] FRAC_LAST  = 8'd127;
  localparam logic [DW-1:0] SEC_LAST   = 8'd59;
  localparam logic [DW-1:0] MIN_LAST   = 8'd59;
  localparam logic [DW-1:0] HOUR_SHORT = 8'd23;
  localparam logic [DW-1:0] HOUR_LONG  = 8'd254;

  typedef logic [DW-1:0] word_t;

  typedef struct packed {
    logic              countEn;
    logic [NSTAGE-1:0] stageWr;
    logic              intvWr;
    word_t             wdata;
    logic [TBW-1:0]    tbSel;
    logic              hr24;
    logic              intvEn;
    logic              oneShot;
  } rtic_stb_t;
endpackage

// File: rtl/rtic_stage.sv
`timescale 1ns/1ps
module rtic_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inc,
  input  logic         wrEn,
  input  logic [W-1:0] wrData,
  input  logic [W-1:0] lastVal,
  output logic [W-1:0] value,
  output logic         wrap
);
  assign wrap = inc && (value >= lastVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      value <= '0;
    else if (wrEn)  value <= wrData;
    else if (inc)   value <= wrap ? '0 : value + 1'b1;
  end
endmodule

// File: rtl/rtic_datapath.sv
`timescale 1ns/1ps
module rtic_datapath
  import rtic_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  rtic_stb_t                  stb,
  output logic [NSTAGE-1:0][DW-1:0]  timeVal,
  output word_t                      intvVal,
  output logic                       intvHit
);
  logic [NSTAGE-1:0] inc;
  logic [NSTAGE-1:0] wrap;
  word_t             lastW [NSTAGE];
  logic              unusedHourWrap;

  assign inc[0] = stb.countEn;
  assign unusedHourWrap = wrap[NSTAGE-1];

  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    if (g == 0) begin : g_frac
      assign lastW[g] = FRAC_LAST;
    end else if (g == 1) begin : g_sec
      assign lastW[g] = SEC_LAST;
    end else if (g == 2) begin : g_min
      assign lastW[g] = MIN_LAST;
    end else begin : g_hour
      assign lastW[g] = stb.hr24 ? HOUR_SHORT : HOUR_LONG;
    end
    if (g > 0) begin : g_carry
      assign inc[g] = wrap[g-1];
    end
    rtic_stage #(.W(DW)) u_stage (
      .clk    (clk),
      .rstN   (rstN),
      .inc    (inc[g]),
      .wrEn   (stb.stageWr[g]),
      .wrData (stb.wdata),
      .lastVal(lastW[g]),
      .value  (timeVal[g]),
      .wrap   (wrap[g])
    );
  end

  // Interval timer
  word_t intvReg;
  word_t cnt;
  word_t nextCnt;
  logic  stopped;
  logic  unitEv;

  assign unitEv  = inc[stb.tbSel];
  assign nextCnt = cnt + 1'b1;
  assign intvHit = stb.intvEn && unitEv && !stopped && (nextCnt == intvReg);
  assign intvVal = intvReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           intvReg <= '0;
    else if (stb.intvWr) intvReg <= stb.wdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      stopped <= 1'b0;
    end else if (!stb.intvEn) begin
      cnt     <= '0;
      stopped <= 1'b0;
    end else if (unitEv && !stopped) begin
      if (nextCnt == intvReg) begin
        cnt     <= '0;
        stopped <= stb.oneShot;
      end else begin
        cnt <= nextCnt;
      end
    end
  end
endmodule

// File: rtl/rtic_ctrl.sv
`timescale 1ns/1ps
module rtic_ctrl
  import rtic_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      tick,
  input  logic                      busWr,
  input  logic [AW-1:0]             busAddr,
  input  word_t                     busWdata,
  input  logic [NSTAGE-1:0][DW-1:0] timeVal,
  input  word_t                     intvVal,
  input  logic                      intvHit,
  output rtic_stb_t                 stb,
  output word_t                     busRdata,
  output logic                      flag
);
  logic           runQ, ienQ, onceQ, h24Q;
  logic [TBW-1:0] tbQ;
  logic           ctrlWr;

  assign ctrlWr = busWr && (busAddr == A_CTRL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ  <= 1'b0;
      ienQ  <= 1'b0;
      onceQ <= 1'b0;
      h24Q  <= 1'b0;
      tbQ   <= '0;
    end else if (ctrlWr) begin
      runQ  <= busWdata[B_RUN];
      ienQ  <= busWdata[B_IEN];
      onceQ <= busWdata[B_ONCE];
      h24Q  <= busWdata[B_H24];
      tbQ   <= busWdata[B_TB +: TBW];
    end
  end

  // Hardware set wins over a software clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           flag <= 1'b0;
    else if (intvHit)                    flag <= 1'b1;
    else if (ctrlWr && busWdata[B_FLAG]) flag <= 1'b0;
  end

  always_comb begin
    stb.countEn = tick && runQ;
    stb.intvWr  = busWr && (busAddr == A_INTV);
    stb.wdata   = busWdata;
    stb.tbSel   = tbQ;
    stb.hr24    = h24Q;
    stb.intvEn  = ienQ;
    stb.oneShot = onceQ;
    for (int i = 0; i < NSTAGE; i++)
      stb.stageWr[i] = busWr && (busAddr == AW'(int'(A_FRAC) + i));
  end

  always_comb begin
    busRdata = '0;
    if (busAddr == A_CTRL) begin
      busRdata[B_RUN]        = runQ;
      busRdata[B_IEN]        = ienQ;
      busRdata[B_FLAG]       = flag;
      busRdata[B_ONCE]       = onceQ;
      busRdata[B_TB +: TBW]  = tbQ;
      busRdata[B_H24]        = h24Q;
    end else if (busAddr == A_INTV) begin
      busRdata = intvVal;
    end else begin
      for (int i = 0; i < NSTAGE; i++)
        if (busAddr == AW'(int'(A_FRAC) + i)) busRdata = timeVal[i];
    end
  end
endmodule

// File: rtl/rtic_top.sv
`timescale 1ns/1ps
module rtic_top
  import rtic_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          tick128,
  input  logic          busWr,
  input  logic [AW-1:0] busAddr,
  input  logic [DW-1:0] busWdata,
  output logic [DW-1:0] busRdata,
  output logic          intvFlag
);
  rtic_stb_t                 stb;
  logic [NSTAGE-1:0][DW-1:0] timeVal;
  word_t                     intvVal;
  logic                      intvHit;

  rtic_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .tick    (tick128),
    .busWr   (busWr),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .timeVal (timeVal),
    .intvVal (intvVal),
    .intvHit (intvHit),
    .stb     (stb),
    .busRdata(busRdata),
    .flag    (intvFlag)
  );

  rtic_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .timeVal(timeVal),
    .intvVal(intvVal),
    .intvHit(intvHit)
  );
endmodule

// File: rtl/rtic_checker.sv
`timescale 1ns/1ps
module rtic_checker
  import rtic_pkg::*;
(
  input logic  clk,
  input logic  rstN,
  input logic  busWr,
  input logic  clrReq,
  input logic  countEn,
  input logic  hr24,
  input logic  intvEn,
  input logic  intvFlag,
  input word_t fracVal,
  input word_t secVal,
  input word_t hourVal
);
  AST_FRAC_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    fracVal <= FRAC_LAST); // R2

  AST_SEC_ROLL: assert property (@(posedge clk) disable iff (!rstN)
    (countEn && !busWr && fracVal == FRAC_LAST && secVal == SEC_LAST) |=> (secVal == '0)); // R3

  AST_HOUR_SHORT: assert property (@(posedge clk) disable iff (!rstN)
    (hr24 && !busWr && hourVal <= HOUR_SHORT) |=> (hourVal <= HOUR_SHORT)); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!countEn && !busWr) |=> ($stable(fracVal) && $stable(secVal) && $stable(hourVal))); // R5

  AST_NO_FLAG_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (!intvEn && !intvFlag) |=> !intvFlag); // R11

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (intvFlag && !clrReq) |=> intvFlag); // R12
endmodule

bind rtic_top rtic_checker u_checker (
  .clk     (clk),
  .rstN    (rstN),
  .busWr   (busWr),
  .clrReq  (busWr && (busAddr == rtic_pkg::A_CTRL) && busWdata[rtic_pkg::B_FLAG]),
  .countEn (stb.countEn),
  .hr24    (stb.hr24),
  .intvEn  (stb.intvEn),
  .intvFlag(intvFlag),
  .fracVal (timeVal[0]),
  .secVal  (timeVal[1]),
  .hourVal (timeVal[3])
);

// File: tb/rtic_top_tb.sv
`timescale 1ns/1ps
module rtic_top_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick128 = 1'b0;
  logic       busWr = 1'b0;
  logic [2:0] busAddr = 3'd0;
  logic [7:0] busWdata = 8'd0;
  logic [7:0] busRdata;
  logic       intvFlag;

  int nChecks = 0;
  int nFails  = 0;
  int mFrac = 0, mSec = 0, mMin = 0, mHour = 0;
  bit mRun = 0, mH24 = 0;

  rtic_top u_dut (
    .clk(clk), .rstN(rstN), .tick128(tick128), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .intvFlag(intvFlag)
  );

  always #2 clk = ~clk;

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ctl(bit run, bit ien, bit once, int tb, bit h24, bit clr);
    logic [7:0] v;
    v = 8'd0;
    v[0] = run; v[1] = ien; v[2] = clr; v[3] = once; v[5:4] = tb[1:0]; v[6] = h24;
    return v;
  endfunction

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output int v);
    busAddr = a;
    #1;
    v = int'(busRdata);
  endtask

  task automatic setCtl(bit run, bit ien, bit once, int tb, bit h24, bit clr);
    mRun = run; mH24 = h24;
    wr(3'd0, ctl(run, ien, once, tb, h24, clr));
  endtask

  task automatic setTime(int f, int s, int m, int h);
    wr(3'd2, 8'(f)); wr(3'd3, 8'(s)); wr(3'd4, 8'(m)); wr(3'd5, 8'(h));
    mFrac = f; mSec = s; mMin = m; mHour = h;
  endtask

  function automatic void modelStep();
    if (!mRun) return;
    mFrac++;
    if (mFrac == 128) begin
      mFrac = 0; mSec++;
      if (mSec == 60) begin
        mSec = 0; mMin++;
        if (mMin == 60) begin
          mMin = 0;
          if (mHour >= (mH24 ? 23 : 254)) mHour = 0; else mHour++;
        end
      end
    end
  endfunction

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick128 = 1'b1;
      @(posedge clk);
      modelStep();
    end
    @(negedge clk);
    tick128 = 1'b0;
  endtask

  task automatic checkTime(string req);
    int f, s, m, h;
    rd(3'd2, f); rd(3'd3, s); rd(3'd4, m); rd(3'd5, h);
    check(req, f + 128 * (s + 60 * (m + 60 * h)),
          mFrac + 128 * (mSec + 60 * (mMin + 60 * mHour)));
  endtask

  // restart the interval timer: enable off, then on
  task automatic arm(bit once, int tb);
    setCtl(1, 0, once, tb, mH24, 1);
    setCtl(1, 1, once, tb, mH24, 0);
  endtask

  initial begin
    #400000;
    nFails++;
    $display("FAIL watchdog R1..all actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset values
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      check("R1 reset register", v, 0);
    end
    check("R1 reset flag", int'(intvFlag), 0);

    // R6 bus map and readback
    wr(3'd1, 8'hA5); rd(3'd1, v); check("R6 interval readback", v, 8'hA5);
    setTime(100, 41, 17, 9);
    rd(3'd2, v); check("R6 fraction readback", v, 100);
    rd(3'd3, v); check("R6 seconds readback", v, 41);
    rd(3'd4, v); check("R6 minutes readback", v, 17);
    rd(3'd5, v); check("R6 hours readback", v, 9);
    setCtl(0, 0, 1, 2, 1, 0);
    rd(3'd0, v); check("R6 control readback", v, 8'h68);
    setCtl(0, 0, 0, 0, 0, 0);
    setTime(0, 0, 0, 0);

    // R5 run off: ticks ignored, interval idle
    wr(3'd1, 8'd1);
    setCtl(0, 1, 0, 0, 0, 0);
    ticks(20);
    checkTime("R5 time held with run off");
    check("R5 no interval hit with run off", int'(intvFlag), 0);
    setCtl(0, 0, 0, 0, 0, 0);

    // R2 R3 sweep over more than one minute, 24h mode
    setCtl(1, 0, 0, 0, 1, 0);
    for (int i = 0; i < 7800; i++) begin
      ticks(1);
      checkTime("R2 R3 cascade");
    end

    // R4 hour wrap in both modes
    setTime(127, 59, 59, 23); ticks(1); checkTime("R4 24h wrap");
    rd(3'd5, v); check("R4 24h hour value", v, 0);
    setCtl(1, 0, 0, 0, 0, 0);
    setTime(127, 59, 59, 23); ticks(1);
    rd(3'd5, v); check("R4 255h mode passes 24", v, 24);
    setTime(127, 59, 59, 254); ticks(1);
    rd(3'd5, v); check("R4 255h wrap", v, 0);
    checkTime("R4 255h cascade");

    // R8 R9 R12 sweep of interval lengths, auto reload, fraction base
    for (int n = 1; n <= 20; n++) begin
      wr(3'd1, 8'(n));
      arm(0, 0);
      if (n > 1) begin
        ticks(n - 1);
        check("R8 no hit before N", int'(intvFlag), 0);
      end
      ticks(1);
      check("R8 hit at N", int'(intvFlag), 1);
      setCtl(1, 1, 0, 0, 0, 1);
      check("R12 write one clears flag", int'(intvFlag), 0);
      ticks(n);
      check("R9 reload hit after N more", int'(intvFlag), 1);
      setCtl(1, 1, 0, 0, 0, 0);
      check("R12 write zero keeps flag", int'(intvFlag), 1);
      setCtl(1, 1, 0, 0, 0, 1);
    end

    // R10 one-shot
    wr(3'd1, 8'd4);
    arm(1, 0);
    ticks(4);
    check("R10 one-shot first hit", int'(intvFlag), 1);
    setCtl(1, 1, 1, 0, 0, 1);
    ticks(12);
    check("R10 one-shot stays stopped", int'(intvFlag), 0);
    arm(1, 0);
    ticks(4);
    check("R10 rearm hits again", int'(intvFlag), 1);

    // R11 disable keeps flag, clears count
    setCtl(1, 0, 0, 0, 0, 0);
    check("R11 disable keeps flag", int'(intvFlag), 1);
    setCtl(1, 0, 0, 0, 0, 1);
    wr(3'd1, 8'd6);
    setCtl(1, 1, 0, 0, 0, 0);
    ticks(4);
    setCtl(1, 0, 0, 0, 0, 0);
    setCtl(1, 1, 0, 0, 0, 0);
    ticks(4);
    check("R11 count restarted from zero", int'(intvFlag), 0);
    ticks(2);
    check("R11 hit after full interval", int'(intvFlag), 1);

    // R8 interval value 0 means 256
    wr(3'd1, 8'd0);
    arm(0, 0);
    ticks(255);
    check("R8 zero interval not at 255", int'(intvFlag), 0);
    ticks(1);
    check("R8 zero interval at 256", int'(intvFlag), 1);

    // R7 timebase seconds: interval 2 from fraction 0
    setCtl(1, 0, 0, 1, 0, 1);
    setTime(0, 10, 0, 0);
    wr(3'd1, 8'd2);
    setCtl(1, 1, 0, 1, 0, 0);
    ticks(255);
    check("R7 seconds base before 2nd second", int'(intvFlag), 0);
    ticks(1);
    check("R7 seconds base at 2nd second", int'(intvFlag), 1);

    // R7 timebase minutes
    setCtl(1, 0, 0, 2, 0, 1);
    setTime(126, 59, 3, 0);
    wr(3'd1, 8'd1);
    setCtl(1, 1, 0, 2, 0, 0);
    ticks(1);
    check("R7 minutes base early", int'(intvFlag), 0);
    ticks(1);
    check("R7 minutes base at rollover", int'(intvFlag), 1);

    // R7 timebase hours
    setCtl(1, 0, 0, 3, 0, 1);
    setTime(126, 59, 59, 5);
    setCtl(1, 1, 0, 3, 0, 0);
    ticks(1);
    check("R7 hours base early", int'(intvFlag), 0);
    ticks(1);
    check("R7 hours base at rollover", int'(intvFlag), 1);
    checkTime("R3 cascade after timebase tests");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule